// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Parallel Read Port

This block is the digital side of a 12-bit successive-approximation converter that sits on a microprocessor-style bus. A read cycle, meaning chip select and read strobe both low, starts a conversion. The block then walks a trial code from the most significant bit down to the least significant bit. It offers each trial code to an external DAC and keeps or drops each bit according to a one-bit comparator answer. When the last bit has been resolved, the final code goes into a result register, and that register is what the bus returns.

The same twelve data lines serve either a 12-bit host or an 8-bit host. When the byte-select input is low, the full word is placed on the bus. When it is high, the upper nibble of the result moves down to lines 3..0 and the lines above it read as zero. A read with the byte-select input high fetches data but never starts a conversion.

There are two read behaviours, and the choice is captured from an input while reset is asserted. In stall mode, the bus stays undriven until a settled result is available, so a read that starts a conversion sees the new code once busy returns high. In immediate mode, every read drives the bus at once with the last latched code. A read that starts a conversion therefore returns the previous result, and a later read returns the new one.

Top module: `sar_read_ctrl`

## Requirements
- R1: During and right after reset, busyN is 1, dataOe is 0, dataOut is 0, and the result register holds 0x000.
- R2: When csN and rdN both become low while hiByteSel is low and no conversion is running, busyN goes low at the next clock edge and stays low for exactly 12 clock cycles.
- R3: Trial bits are resolved from bit 11 down to bit 0, one bit per clock. A bit is kept when cmpHigh is 1, meaning the input is at or above dacCode. The final result is the straight-binary code of the input, so 0x000, 0x800 and 0xFFF come out as themselves.
- R4: The result register changes only at the clock edge where busyN returns high. A read during a conversion never shows a partly resolved code.
- R5: An access that begins while a conversion is running neither restarts nor lengthens that conversion.
- R6: With hiByteSel low and the bus enabled, dataOut[11:0] carries result bits 11..0.
- R7: With hiByteSel high and the bus enabled, dataOut[3:0] carries result bits 11..8 and dataOut[11:4] is 0. Such a read starts no conversion.
- R8: Whenever dataOe is 0, dataOut is all zero. dataOe is 0 whenever csN or rdN is high.
- R9: In stall mode (romMode sampled as 0), dataOe is 1 only when the access has been held across at least one clock edge and no conversion is running. A read that starts a conversion therefore returns the new result once busyN is high again.
- R10: In immediate mode (romMode sampled as 1), dataOe is 1 in the same cycle that csN and rdN are both low. A read that starts a conversion returns the previously latched result.
- R11: romMode is captured only while rstN is low. Changing it afterwards has no effect.
- R12: In immediate mode with byte reads, the read that starts a conversion returns the old low byte. A byte-select read after the conversion returns the new upper nibble. A following low-byte read returns the new low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Asynchronous reset, active low |
| romMode | input | 1 | Read mode, captured during reset: 0 stall, 1 immediate |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| hiByteSel | input | 1 | 1 selects the upper-nibble byte view; 0 selects the full word |
| cmpHigh | input | 1 | Comparator: 1 when the analog input is at or above dacCode |
| dacCode | output | 12 | Trial code for the DAC |
| busyN | output | 1 | Low while a conversion is running |
| dataOut | output | 12 | Read data, zero when not enabled |
| dataOe | output | 1 | Bus drive enable |

## Verification
A miscounted bit index shows up as a busy pulse that is not exactly 12 cycles long. It also appears as a wrong code on the very read that ends the conversion, in whichever mode the block is in. A result register that updates too early, or that holds stale data, can be seen within one read in immediate mode: a mid-conversion read shows a partial code, or a read after busy returns high shows the old one. Sweeping all 4096 comparator targets in both modes makes a single wrong keep-or-drop decision on any bit visible as a code mismatch at the end of the affected conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef struct packed {
    logic load;   // begin a conversion with only the MSB trial bit set
    logic step;   // resolve the current bit and set the next trial bit
    logic latch;  // final bit resolved: copy the code to the result
  } sarStrobe_t;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 12,
  parameter int IDXW  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            romMode,
  input  logic            access,
  input  logic            hiByteSel,
  output sarStrobe_t      strobe,
  output logic [IDXW-1:0] bitIdx,
  output logic            busy,
  output logic            dataOe
);
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(WIDTH - 1);

  logic            accessQ;
  logic            modeQ;
  logic            busyQ;
  logic [IDXW-1:0] idxQ;
  logic            startReq;

  // Only a fresh word access from idle starts a conversion
  assign startReq = access & ~accessQ & ~hiByteSel & ~busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accessQ <= 1'b0;
      modeQ   <= romMode;
      busyQ   <= 1'b0;
      idxQ    <= '0;
    end else begin
      accessQ <= access;
      if (startReq) begin
        busyQ <= 1'b1;
        idxQ  <= TOP_IDX;
      end else if (busyQ) begin
        if (idxQ == '0) busyQ <= 1'b0;
        else            idxQ  <= idxQ - 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load  = startReq;
    strobe.step  = busyQ;
    strobe.latch = busyQ & (idxQ == '0);
  end

  assign bitIdx = idxQ;
  assign busy   = busyQ;
  assign dataOe = access & (modeQ | (accessQ & ~busyQ));

  // R2: conversion ends right after the last bit
  p_busy_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && (idxQ == '0) |=> !busyQ);
  // R2: a start loads the top bit index
  p_start_top_r2: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> busyQ && (idxQ == TOP_IDX));
  // R5: a running conversion only counts down, whatever the bus does
  p_no_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && (idxQ != '0) |=> busyQ && (idxQ == $past(idxQ) - 1'b1));
  // R9: stall mode never drives the bus during a conversion
  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !modeQ && busyQ |-> !dataOe);
  // R11: captured mode never changes outside reset
  p_mode_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(modeQ));
endmodule

// File: rtl/sar_dpath.sv
module sar_dpath
  import sar_pkg::*;
#(
  parameter int WIDTH = 12,
  parameter int IDXW  = 4,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobe_t       strobe,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic             cmpHigh,
  input  logic             hiByteSel,
  input  logic             dataOe,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] dataOut
);
  localparam int HI_W = WIDTH - LOW_W;
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] sarQ;
  logic [WIDTH-1:0] resultQ;
  logic [WIDTH-1:0] nextSar;
  logic [WIDTH-1:0] byteView;

  always_comb begin
    nextSar = sarQ;
    nextSar[bitIdx] = cmpHigh;
    if (bitIdx != '0) nextSar[IDXW'(bitIdx - 1'b1)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarQ    <= '0;
      resultQ <= '0;
    end else begin
      if (strobe.load)      sarQ <= MSB_ONLY;
      else if (strobe.step) sarQ <= nextSar;
      if (strobe.latch)     resultQ <= nextSar;
    end
  end

  assign byteView = {{(WIDTH-HI_W){1'b0}}, resultQ[WIDTH-1:LOW_W]};
  assign dacCode  = sarQ;
  assign dataOut  = !dataOe ? '0 : (hiByteSel ? byteView : resultQ);

  // R4: result moves only on the final-bit strobe
  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latch |=> $stable(resultQ));
  // R7: upper lines are low in the byte view
  p_byte_upper_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataOe && hiByteSel |-> dataOut[WIDTH-1:HI_W] == '0);
  // R8: undriven bus reads as zero
  p_bus_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> dataOut == '0);
endmodule

// File: rtl/sar_read_ctrl.sv
module sar_read_ctrl
  import sar_pkg::*;
#(
  parameter int WIDTH = 12,
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             romMode,
  input  logic             csN,
  input  logic             rdN,
  input  logic             hiByteSel,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] dacCode,
  output logic             busyN,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataOe
);
  localparam int IDXW = $clog2(WIDTH);

  sarStrobe_t      strobe;
  logic [IDXW-1:0] bitIdx;
  logic            busy;
  logic            access;

  assign access = ~csN & ~rdN;
  assign busyN  = ~busy;

  sar_ctrl #(.WIDTH(WIDTH), .IDXW(IDXW)) u_ctrl (
    .clk(clk), .rstN(rstN), .romMode(romMode), .access(access),
    .hiByteSel(hiByteSel), .strobe(strobe), .bitIdx(bitIdx),
    .busy(busy), .dataOe(dataOe)
  );

  sar_dpath #(.WIDTH(WIDTH), .IDXW(IDXW), .LOW_W(LOW_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIdx(bitIdx),
    .cmpHigh(cmpHigh), .hiByteSel(hiByteSel), .dataOe(dataOe),
    .dacCode(dacCode), .dataOut(dataOut)
  );
endmodule

// File: tb/sar_read_ctrl_test.sv
module sar_read_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        romMode = 1'b0;
  logic        csN = 1'b1;
  logic        rdN = 1'b1;
  logic        hiByteSel = 1'b0;
  logic        cmpHigh;
  logic [11:0] dacCode;
  logic        busyN;
  logic [11:0] dataOut;
  logic        dataOe;

  int target = 0;
  int prev = 0;
  bit romNow = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // comparator model: input at or above trial code
  assign cmpHigh = (int'(dacCode) <= target);

  sar_read_ctrl uut (
    .clk(clk), .rstN(rstN), .romMode(romMode), .csN(csN), .rdN(rdN),
    .hiByteSel(hiByteSel), .cmpHigh(cmpHigh), .dacCode(dacCode),
    .busyN(busyN), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int hiView(input int v);
    return (v >> 8) & 'hF;
  endfunction

  task automatic doReset(input bit m);
    @(negedge clk);
    rstN = 1'b0; romMode = m; csN = 1'b1; rdN = 1'b1; hiByteSel = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1; #2;
    chk(busyN == 1'b1, "R1 busyN", busyN, 1);
    chk(dataOe == 1'b0 && dataOut == 12'h0, "R1 bus", dataOut, 0);
    romNow = m; prev = 0;
  endtask

  // word read that starts a conversion and is held until busy returns high
  task automatic convert(input int tgt);
    int cnt;
    target = tgt;
    @(negedge clk); csN = 1'b0; rdN = 1'b0; hiByteSel = 1'b0; #2;
    if (romNow) chk(dataOe && dataOut == prev[11:0], "R10 old result", dataOut, prev);
    else        chk(!dataOe, "R9 stall", dataOe, 0);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #2;
      if (busyN) break;
      if (!romNow) chk(!dataOe, "R9 busy quiet", dataOe, 0);
      cnt++;
    end
    chk(cnt == 12, "R2 busy length", cnt, 12);
    chk(dataOe && dataOut == tgt[11:0], "R3 R6 result", dataOut, tgt);
    csN = 1'b1; rdN = 1'b1; #1;
    chk(!dataOe && dataOut == 12'h0, "R8 released", dataOut, 0);
    prev = tgt;
  endtask

  task automatic byteRead(input int expHi);
    @(negedge clk); csN = 1'b0; rdN = 1'b0; hiByteSel = 1'b1; #2;
    if (!romNow) begin
      chk(!dataOe, "R9 first cycle", dataOe, 0);
      @(negedge clk); #2;
    end
    chk(dataOe && dataOut == expHi[11:0], "R7 byte view", dataOut, expHi);
    @(negedge clk); csN = 1'b1; rdN = 1'b1; hiByteSel = 1'b0; #2;
    chk(busyN == 1'b1, "R7 no start", busyN, 1);
  endtask

  // ROM mode: read during a conversion
  task automatic midRead(input int tgt);
    int cnt;
    target = tgt;
    @(negedge clk); csN = 1'b0; rdN = 1'b0; #2;
    @(negedge clk); csN = 1'b1; rdN = 1'b1;
    repeat (3) @(negedge clk);
    csN = 1'b0; rdN = 1'b0; #2;
    chk(dataOe && dataOut == prev[11:0], "R4 no partial code", dataOut, prev);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #2;
      if (busyN) break;
      cnt++;
    end
    chk(cnt == 8, "R5 not restarted", cnt, 8);
    chk(dataOut == tgt[11:0], "R4 new result", dataOut, tgt);
    csN = 1'b1; rdN = 1'b1;
    prev = tgt;
  endtask

  initial begin
    int seedVal;
    int t2;
    seedVal = $urandom(32'h5A17);
    doReset(1'b0);
    byteRead(0);
    convert(0); convert('h800); convert('hFFF);
    romMode = 1'b1;               // R11: ignored after reset
    byteRead(hiView('hFFF));
    romMode = 1'b0;
    convert('h5A3);
    byteRead(hiView('h5A3));
    for (int c = 0; c < 4096; c++) convert(c);

    doReset(1'b1);
    convert('h800);               // R1: first read returns zero
    for (int c = 0; c < 4096; c++) convert(4095 - c);
    byteRead(hiView(prev));
    for (int k = 0; k < 10; k++) midRead(int'($urandom % 4096));
    for (int k = 0; k < 20; k++) begin
      t2 = int'($urandom % 4096);
      target = t2;
      @(negedge clk); csN = 1'b0; rdN = 1'b0; hiByteSel = 1'b0; #2;
      chk(dataOut[7:0] == prev[7:0], "R12 old low byte", dataOut[7:0], prev & 'hFF);
      @(negedge clk); csN = 1'b1; rdN = 1'b1;
      repeat (14) @(negedge clk);
      csN = 1'b0; rdN = 1'b0; hiByteSel = 1'b1; #2;
      chk(dataOut == hiView(t2), "R12 new high nibble", dataOut, hiView(t2));
      @(negedge clk); csN = 1'b1; rdN = 1'b1; hiByteSel = 1'b0; #2;
      chk(busyN, "R7 no start", busyN, 1);
      @(negedge clk); csN = 1'b0; rdN = 1'b0; #2;
      chk(dataOut[7:0] == t2[7:0], "R12 new low byte", dataOut[7:0], t2 & 'hFF);
      @(negedge clk); csN = 1'b1; rdN = 1'b1;
      repeat (14) @(negedge clk);
      prev = t2;
    end
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule